// File: doc/BRIEF.md
# Delay-Locked-Loop Lane Bring-Up Sequencer

This block releases one master clock-phase DLL lane and a group of slave byte-lane DLLs into operation after a single start pulse. A packed phase word supplies the phase setting of every lane. The sequencer captures that word when it accepts the start pulse. It then takes the master lane through three timed steps, and after that takes the active slave lanes through the same three steps together. In the first step the lane is disabled and held in reset. In the second step the lane is enabled and still in reset. In the third step the lane is enabled and out of reset.

The wait in each step is a number of clock cycles. That number is derived from a clock-frequency parameter (in MHz) and a duration in microseconds. The short wait defaults to 2 µs and the long wait to 22 µs. A bus-width input, captured with the start pulse, decides how many slave lanes take part. Lanes that do not take part stay disabled, held in reset and at phase zero. A one-cycle done pulse marks the end of the sequence.

Top module: `dll_lane_seq`

## Requirements
- R1: After reset, busy and done are 0. Every lane output shows disable=1 and active-low reset=0, and every phase output is 0.
- R2: A start pulse accepted while idle captures the phase word. The master phase becomes word bits 21:16. Slave lane k (k counted from 0) gets word bits 4k+3:4k. Later changes on the word have no effect until the next accepted start.
- R3: The master first shows disable=1 and reset=0 for SHORT_CYC cycles (CLK_MHZ*2) counted from the start edge. During this step every slave lane shows the same outputs.
- R4: Next, the master shows disable=0 and reset=0 for LONG_CYC cycles (CLK_MHZ*22).
- R5: Next, the master shows disable=0 and reset=1. It keeps these outputs after the sequence ends and until the next accepted start.
- R6: No slave lane leaves disable=1/reset=0 until the master's third step has lasted LONG_CYC cycles. After that, all active slave lanes move together through the same three steps: SHORT_CYC, then LONG_CYC, then LONG_CYC cycles.
- R7: With wide=1, slave lanes 0 to 3 are active. With wide=0, only lanes 0 and 1 are active. Inactive lanes show disable=1, reset=0 and phase 0 at all times.
- R8: Done is high for exactly one cycle. This happens 2*SHORT_CYC+4*LONG_CYC cycles after the accepted start edge, and busy falls in the same cycle. Active slaves then keep disable=0 and reset=1.
- R9: A start pulse while busy is ignored. The phases, the lane set and the step timing of the running sequence do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up sequence (accepted only when idle) |
| wide | input | 1 | 1 = wide data bus (all slave lanes), 0 = narrow (half) |
| phase_word | input | 22 | Packed phase settings for all lanes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| mst_phase | output | 6 | Master lane clock-phase field |
| mst_rst_n | output | 1 | Master lane active-low reset |
| mst_dis | output | 1 | Master lane disable |
| slv_phase | output | 16 | Slave phase fields, lane k at bits 4k+3:4k |
| slv_rst_n | output | 4 | Slave lane active-low resets |
| slv_dis | output | 4 | Slave lane disables |

## Verification
The hardest case to reach is a stray start pulse that lands while the sequence is running. To show that it is ignored, the bench must confirm that nothing moves afterwards: neither the captured phases, nor the lane set, nor the step boundaries. Some table rows inject such a pulse in the middle of the master's enable step. That pulse carries a different bus width and a different word. The bench then checks every later step boundary at the exact cycle. The bench also switches the bus width from wide to narrow between runs. This shows that lanes released by an earlier run drop back to off.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_M_HOLD,
        SQ_M_EN,
        SQ_M_REL,
        SQ_S_HOLD,
        SQ_S_EN,
        SQ_S_REL
    } seq_state_e;

    // Step a lane group is in; LN_HOLD doubles as the "off" state
    typedef enum logic [1:0] {
        LN_HOLD,
        LN_EN,
        LN_ON
    } lane_step_e;

endpackage

// File: rtl/dll_wait_timer.sv
module dll_wait_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/dll_lane_drive.sv
module dll_lane_drive
    import dll_seq_pkg::*;
(
    input  lane_step_e step_i,
    input  logic       en_i,
    output logic       rst_n_o,
    output logic       dis_o
);

    always_comb begin
        dis_o   = 1'b1;
        rst_n_o = 1'b0;
        if (en_i) begin
            case (step_i)
                LN_EN: begin
                    dis_o   = 1'b0;
                    rst_n_o = 1'b0;
                end
                LN_ON: begin
                    dis_o   = 1'b0;
                    rst_n_o = 1'b1;
                end
                default: begin
                    dis_o   = 1'b1;
                    rst_n_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dll_lane_seq.sv
module dll_lane_seq
    import dll_seq_pkg::*;
#(
    parameter int CLK_MHZ  = 125,
    parameter int SHORT_US = 2,
    parameter int LONG_US  = 22,
    parameter int N_SLAVE  = 4,
    parameter int SLV_PW   = 4,
    parameter int MST_W    = 6,
    parameter int MST_LSB  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      wide,
    input  logic [MST_LSB+MST_W-1:0]  phase_word,
    output logic                      busy,
    output logic                      done,
    output logic [MST_W-1:0]          mst_phase,
    output logic                      mst_rst_n,
    output logic                      mst_dis,
    output logic [N_SLAVE*SLV_PW-1:0] slv_phase,
    output logic [N_SLAVE-1:0]        slv_rst_n,
    output logic [N_SLAVE-1:0]        slv_dis
);

    localparam int SHORT_CYC = CLK_MHZ * SHORT_US;
    localparam int LONG_CYC  = CLK_MHZ * LONG_US;
    localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int SLV_BITS  = N_SLAVE * SLV_PW;
    localparam int N_NARROW  = N_SLAVE / 2;
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);

    typedef struct packed {
        seq_state_e          st;
        lane_step_e          mst_step;
        lane_step_e          slv_step;
        logic                wide;
        logic                done;
        logic [MST_W-1:0]    mph;
        logic [SLV_BITS-1:0] sph;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        st:       SQ_IDLE,
        mst_step: LN_HOLD,
        slv_step: LN_HOLD,
        wide:     1'b1,
        done:     1'b0,
        mph:      '0,
        sph:      '0
    };

    seq_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic [N_SLAVE-1:0] lane_act;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = SHORT_LD;
        case (r_q.st)
            SQ_IDLE: begin
                if (start) begin
                    r_d.st       = SQ_M_HOLD;
                    r_d.mst_step = LN_HOLD;
                    r_d.slv_step = LN_HOLD;
                    r_d.wide     = wide;
                    r_d.mph      = phase_word[MST_LSB +: MST_W];
                    for (int k = 0; k < N_SLAVE; k++) begin
                        if (wide || k < N_NARROW)
                            r_d.sph[k*SLV_PW +: SLV_PW] = phase_word[k*SLV_PW +: SLV_PW];
                        else
                            r_d.sph[k*SLV_PW +: SLV_PW] = '0;
                    end
                    tmr_load = 1'b1;
                    tmr_val  = SHORT_LD;
                end
            end
            SQ_M_HOLD: if (tmr_exp) begin
                r_d.st       = SQ_M_EN;
                r_d.mst_step = LN_EN;
                tmr_load     = 1'b1;
                tmr_val      = LONG_LD;
            end
            SQ_M_EN: if (tmr_exp) begin
                r_d.st       = SQ_M_REL;
                r_d.mst_step = LN_ON;
                tmr_load     = 1'b1;
                tmr_val      = LONG_LD;
            end
            SQ_M_REL: if (tmr_exp) begin
                r_d.st   = SQ_S_HOLD;
                tmr_load = 1'b1;
                tmr_val  = SHORT_LD;
            end
            SQ_S_HOLD: if (tmr_exp) begin
                r_d.st       = SQ_S_EN;
                r_d.slv_step = LN_EN;
                tmr_load     = 1'b1;
                tmr_val      = LONG_LD;
            end
            SQ_S_EN: if (tmr_exp) begin
                r_d.st       = SQ_S_REL;
                r_d.slv_step = LN_ON;
                tmr_load     = 1'b1;
                tmr_val      = LONG_LD;
            end
            SQ_S_REL: if (tmr_exp) begin
                r_d.st   = SQ_IDLE;
                r_d.done = 1'b1;
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= REGS_RST;
        else
            r_q <= r_d;
    end

    dll_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    dll_lane_drive u_mst (
        .step_i  (r_q.mst_step),
        .en_i    (1'b1),
        .rst_n_o (mst_rst_n),
        .dis_o   (mst_dis)
    );

    for (genvar k = 0; k < N_SLAVE; k++) begin : g_slv
        assign lane_act[k] = r_q.wide || (k < N_NARROW);
        dll_lane_drive u_slv (
            .step_i  (r_q.slv_step),
            .en_i    (lane_act[k]),
            .rst_n_o (slv_rst_n[k]),
            .dis_o   (slv_dis[k])
        );
    end

    assign busy      = (r_q.st != SQ_IDLE);
    assign done      = r_q.done;
    assign mst_phase = r_q.mph;
    assign slv_phase = r_q.sph;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_SLAVE_AFTER_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~slv_dis)) |-> (mst_rst_n && !mst_dis)); // R6

    AST_MST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_rst_n) |-> $past(!mst_dis)); // R5

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(mst_phase) && $stable(slv_phase))); // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

endmodule

// File: tb/sim_dll_lane_seq.sv
module sim_dll_lane_seq;

    localparam int SHORT = 125 * 2;
    localparam int LONG  = 125 * 22;
    localparam int NV    = 4;

    // {wide, phase_word[21:0], exp mst_phase, exp slv_phase, exp active mask}
    localparam logic [48:0] TV [NV] = '{
        {1'b1, 22'h2A8421, 6'h2A, 16'h8421, 4'b1111},
        {1'b0, 22'h15FEDC, 6'h15, 16'h00DC, 4'b0011},
        {1'b1, 22'h3F0000, 6'h3F, 16'h0000, 4'b1111},
        {1'b0, 22'h0ABCDE, 6'h0A, 16'h00DE, 4'b0011}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide = 1'b1;
    logic [21:0] phase_word = '0;
    logic        busy, done, mst_rst_n, mst_dis;
    logic [5:0]  mst_phase;
    logic [15:0] slv_phase;
    logic [3:0]  slv_rst_n, slv_dis;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dll_lane_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
        .phase_word(phase_word), .busy(busy), .done(done),
        .mst_phase(mst_phase), .mst_rst_n(mst_rst_n), .mst_dis(mst_dis),
        .slv_phase(slv_phase), .slv_rst_n(slv_rst_n), .slv_dis(slv_dis)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic stray_start(input logic w, input logic [21:0] pw);
        wide = w; phase_word = pw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_seq(input logic [48:0] v, input bit inject);
        logic        w   = v[48];
        logic [21:0] pw  = v[47:26];
        logic [5:0]  mph = v[25:20];
        logic [15:0] sph = v[19:4];
        logic [3:0]  msk = v[3:0];
        @(negedge clk);
        wide = w; phase_word = pw; start = 1'b1;
        @(negedge clk);
        start = 1'b0; phase_word = ~pw; wide = ~w;
        check("R2 busy", {31'd0, busy}, 32'd1);
        check("R2 mst_phase", {26'd0, mst_phase}, {26'd0, mph});
        check("R7 slv_phase", {16'd0, slv_phase}, {16'd0, sph});
        check("R3 mst step1", {30'd0, mst_dis, mst_rst_n}, 32'd2);
        check("R3 slaves held", {28'd0, slv_dis}, 32'hF);
        wait_n(SHORT - 1);
        check("R3 mst step1 end", {30'd0, mst_dis, mst_rst_n}, 32'd2);
        wait_n(1);
        check("R4 mst step2", {30'd0, mst_dis, mst_rst_n}, 32'd0);
        if (inject) begin
            wait_n(10);
            stray_start(~w, 22'h155555);
            wait_n(LONG - 12);
        end else begin
            wait_n(LONG - 1);
        end
        check("R4 mst step2 end", {30'd0, mst_dis, mst_rst_n}, 32'd0);
        wait_n(1);
        check("R5 mst step3", {30'd0, mst_dis, mst_rst_n}, 32'd1);
        wait_n(LONG - 1);
        check("R6 slaves wait", {24'd0, slv_dis, slv_rst_n}, 32'hF0);
        wait_n(1);
        check("R5 mst stays on", {30'd0, mst_dis, mst_rst_n}, 32'd1);
        check("R6 slv step1", {24'd0, slv_dis, slv_rst_n}, 32'hF0);
        wait_n(SHORT - 1);
        check("R6 slv step1 end", {24'd0, slv_dis, slv_rst_n}, 32'hF0);
        wait_n(1);
        check("R7 slv step2", {24'd0, slv_dis, slv_rst_n}, {24'd0, ~msk, 4'h0});
        wait_n(LONG);
        check("R7 slv step3", {24'd0, slv_dis, slv_rst_n}, {24'd0, ~msk, msk});
        wait_n(LONG - 1);
        check("R8 not yet done", {30'd0, busy, done}, 32'd2);
        wait_n(1);
        check("R8 done pulse", {30'd0, busy, done}, 32'd1);
        check("R9 phases kept", {10'd0, mst_phase, slv_phase}, {10'd0, mph, sph});
        wait_n(1);
        check("R8 done single", {31'd0, done}, 32'd0);
        check("R8 lanes hold", {22'd0, mst_dis, mst_rst_n, slv_dis, slv_rst_n},
              {22'd0, 2'b01, ~msk, msk});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_n(3);
        check("R1 reset busy/done", {30'd0, busy, done}, 32'd0);
        check("R1 reset lanes", {22'd0, mst_dis, mst_rst_n, slv_dis, slv_rst_n}, 32'h2F0);
        check("R1 reset phases", {10'd0, mst_phase, slv_phase}, 32'd0);
        rst_n = 1'b1;
        wait_n(2);
        check("R1 idle after reset", {22'd0, mst_dis, mst_rst_n, slv_dis, slv_rst_n}, 32'h2F0);

        for (int i = 0; i < NV; i++)
            run_seq(TV[i], (i % 2) == 1);

        // Directed: reset in mid-sequence returns to the reset state
        @(negedge clk);
        wide = 1'b1; phase_word = 22'h2A8421; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_n(SHORT + 40);
        rst_n = 1'b0;
        wait_n(1);
        check("R1 mid-run reset", {20'd0, busy, done, mst_dis, mst_rst_n, slv_dis, slv_rst_n},
              32'h2F0);
        check("R1 mid-run reset phase", {10'd0, mst_phase, slv_phase}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule